// File: doc/BRIEF.md
# Embedded Timing Code Video Decoder

The block takes an 8-bit interleaved 4:2:2 video byte stream, one byte per clock. All line and field timing comes from reference codes embedded in that stream. Each code is a three-byte preamble FF, 00, 00 followed by a status byte. The decoder recognises each code and extracts the field, vertical-blank and horizontal flags from the status byte. It holds those flags on registered outputs and re-times the data byte by one clock. Alongside the data it drives an enable that marks the active picture bytes of lines outside vertical blanking.

It also watches how far apart the end-of-active-video codes arrive. When two consecutive line periods match the selected standard, it raises a lock output. The lock falls when a code comes at the wrong spacing, or when a full line period passes with no code at all. A select input picks between the 525-line (1716 clocks per line) and 625-line (1728 clocks per line) line lengths.

Top module: `vid_sync_decoder`

## Requirements
- R1: While reset is held and in the first cycle after it, dout, de, h_flag, v_flag, f_flag and locked are all 0.
- R2: A timing code is the byte FF, then 00, then 00, then a status byte whose bit 7 is 1. In the status byte, bit 6 is F, bit 5 is V and bit 4 is H. Bits 3 to 0 have no effect. H=1 marks an end-of-active-video code and H=0 marks a start-of-active-video code.
- R3: One clock after a status byte enters, f_flag, v_flag and h_flag take its F, V and H values. They keep those values until the next timing code.
- R4: An incomplete preamble (such as FF, 00, FF) has no effect on the flags or on de. So does a full preamble followed by a byte with bit 7 at 0.
- R5: dout equals din delayed by one clock.
- R6: After a start code with V=0, de is high, aligned with dout, for exactly the 1440 bytes that follow the status byte. de is low for the code bytes themselves and outside that window. Any timing code ends the window early.
- R7: After a start code with V=1, de stays low for the whole line.
- R8: The line length L is 1716 clocks when sel_625=0 and 1728 clocks when sel_625=1. locked rises one clock after an end code that closes the second consecutive end-to-end spacing of exactly L clocks.
- R9: An end code that arrives at a spacing other than L from the previous one clears locked one clock later. That code becomes the start of a new count of two spacings.
- R10: If L clocks pass after an end code and no new end code arrives in that clock, locked is cleared one clock later. This also happens when the code is only one clock late.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_625 | input | 1 | Line standard: 0 selects 1716 clocks per line, 1 selects 1728 |
| din | input | 8 | Incoming video byte |
| dout | output | 8 | din re-timed by one clock |
| de | output | 1 | Active picture byte on dout |
| h_flag | output | 1 | H bit of the latest timing code |
| v_flag | output | 1 | V bit of the latest timing code |
| f_flag | output | 1 | F bit of the latest timing code |
| locked | output | 1 | Code spacing matches the selected line length |

## Verification
The line-period check can meet the missing-code timeout in the same clock. In the clock where the next end code is due, one exact-spacing decision either extends the lock or lets it lapse. The bench provokes this with lines that are exactly L long, where code arrival and the timeout limit coincide and the lock must hold. It also sends one line a single clock too long, where the timeout must win one clock before the late code, and then checks that the late code does not restore the lock. A second overlap is a timing code inside an open active window: the code must close de in the very clock its status byte enters, and this is judged against a bench model that counts bytes since the last start code.

// File: rtl/vsd_pkg.sv
package vsd_pkg;

  typedef struct packed {
    logic f;
    logic v;
    logic h;
  } vsd_flags_t;

  // Status byte layout: [6]=F, [5]=V, [4]=H, low nibble unused here
  function automatic vsd_flags_t xy_decode(input logic [7:0] xy);
    vsd_flags_t r;
    r.f = xy[6];
    r.v = xy[5];
    r.h = xy[4];
    return r;
  endfunction

  // Full line: two 4-byte codes, the blanking gap and the active run
  function automatic int unsigned line_clocks(input int unsigned act,
                                              input int unsigned blank);
    return act + blank + 8;
  endfunction

endpackage

// File: rtl/vsd_preamble.sv
module vsd_preamble #(
  parameter int DW      = 8,
  parameter int PRE_LEN = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  output logic          code_hit
);

  logic [PRE_LEN-1:0] stage_ok;

  // stage 0 holds the newest past byte; the oldest stage must be all ones
  for (genvar i = 0; i < PRE_LEN; i++) begin : g_stage
    logic [DW-1:0] q;
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= din;
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= g_stage[i-1].q;
      end
    end
    if (i == PRE_LEN - 1) begin : g_ones
      assign stage_ok[i] = (q == {DW{1'b1}});
    end else begin : g_zeros
      assign stage_ok[i] = (q == '0);
    end
  end

  assign code_hit = (&stage_ok) && din[DW-1];

endmodule

// File: rtl/vsd_flags.sv
module vsd_flags
  import vsd_pkg::*;
#(
  parameter int DW       = 8,
  parameter int ACT_CLKS = 1440
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] din,
  input  logic          code_hit,
  output logic          eav_hit,
  output logic [DW-1:0] dout,
  output logic          de,
  output vsd_flags_t    flg
);

  localparam int ACW = $clog2(ACT_CLKS + 1);

  vsd_flags_t     dec;
  logic           sav_open;
  logic [ACW-1:0] left;

  assign dec      = xy_decode(din[7:0]);
  assign eav_hit  = code_hit && dec.h;
  assign sav_open = code_hit && !dec.h && !dec.v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout <= '0;
      de   <= 1'b0;
      flg  <= '0;
      left <= '0;
    end else begin
      dout <= din;
      de   <= (left != '0) && !code_hit;
      if (code_hit) begin
        flg  <= dec;
        left <= sav_open ? ACW'(ACT_CLKS) : '0;
      end else if (left != '0) begin
        left <= left - 1'b1;
      end
    end
  end

endmodule

// File: rtl/vsd_lock.sv
module vsd_lock #(
  parameter int LINE_A     = 1716,
  parameter int LINE_B     = 1728,
  parameter int LOCK_LINES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_b,
  input  logic eav_hit,
  output logic span_ok,
  output logic timeout,
  output logic locked
);

  localparam int LMAX = (LINE_A > LINE_B) ? LINE_A : LINE_B;
  localparam int CW   = $clog2(LMAX + 1);
  localparam int GW   = $clog2(LOCK_LINES + 1);

  logic [CW-1:0] since;
  logic [CW-1:0] limit;
  logic [GW-1:0] good;
  logic          seen;

  assign limit   = sel_b ? CW'(LINE_B - 1) : CW'(LINE_A - 1);
  assign span_ok = eav_hit && seen && (since == limit);
  assign timeout = !eav_hit && (since >= limit);
  assign locked  = (good == GW'(LOCK_LINES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since <= '0;
      good  <= '0;
      seen  <= 1'b0;
    end else begin
      if (eav_hit)      since <= '0;
      else if (!(&since)) since <= since + 1'b1;

      if (eav_hit) begin
        seen <= 1'b1;
        if (!span_ok)                      good <= '0;
        else if (good != GW'(LOCK_LINES))  good <= good + 1'b1;
      end else if (timeout) begin
        seen <= 1'b0;
        good <= '0;
      end
    end
  end

endmodule

// File: rtl/vid_sync_decoder.sv
module vid_sync_decoder
  import vsd_pkg::*;
#(
  parameter int DW         = 8,
  parameter int ACT_CLKS   = 1440,
  parameter int BLANK_A    = 268,
  parameter int BLANK_B    = 280,
  parameter int LOCK_LINES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_625,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          de,
  output logic          h_flag,
  output logic          v_flag,
  output logic          f_flag,
  output logic          locked
);

  localparam int LINE_A = int'(line_clocks(ACT_CLKS, BLANK_A));
  localparam int LINE_B = int'(line_clocks(ACT_CLKS, BLANK_B));

  logic       code_hit;
  logic       eav_hit;
  logic       span_ok;
  logic       timeout;
  vsd_flags_t flg;

  vsd_preamble #(.DW(DW), .PRE_LEN(3)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .code_hit (code_hit)
  );

  vsd_flags #(.DW(DW), .ACT_CLKS(ACT_CLKS)) u_flg (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .code_hit (code_hit),
    .eav_hit  (eav_hit),
    .dout     (dout),
    .de       (de),
    .flg      (flg)
  );

  vsd_lock #(.LINE_A(LINE_A), .LINE_B(LINE_B), .LOCK_LINES(LOCK_LINES)) u_lck (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_b    (sel_625),
    .eav_hit  (eav_hit),
    .span_ok  (span_ok),
    .timeout  (timeout),
    .locked   (locked)
  );

  assign h_flag = flg.h;
  assign v_flag = flg.v;
  assign f_flag = flg.f;

endmodule

// File: rtl/vid_sync_decoder_chk.sv
module vid_sync_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       code_hit,
  input logic       eav_hit,
  input logic       span_ok,
  input logic       timeout,
  input logic [2:0] st_fvh,
  input logic       h_flag,
  input logic       v_flag,
  input logic       f_flag,
  input logic       de,
  input logic       locked
);

  AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !code_hit |=> $stable({f_flag, v_flag, h_flag})); // R3

  AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    code_hit |=> ({f_flag, v_flag, h_flag} == $past(st_fvh))); // R2

  AST_DE_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    de |-> (!h_flag && !v_flag)); // R6

  AST_LOCK_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(span_ok)); // R8

  AST_LOCK_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> ($past(eav_hit) || $past(timeout))); // R9

  AST_LOCK_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> !locked); // R10

endmodule

bind vid_sync_decoder vid_sync_decoder_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .code_hit (code_hit),
  .eav_hit  (eav_hit),
  .span_ok  (span_ok),
  .timeout  (timeout),
  .st_fvh   (din[6:4]),
  .h_flag   (h_flag),
  .v_flag   (v_flag),
  .f_flag   (f_flag),
  .de       (de),
  .locked   (locked)
);

// File: tb/vid_sync_decoder_bench.sv
module vid_sync_decoder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int ACT        = 1440;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_625 = 1'b0;
  logic [7:0] din = 8'h00;
  logic [7:0] dout;
  logic       de, h_flag, v_flag, f_flag, locked;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] m0 = 8'h00, m1 = 8'h00, m2 = 8'h00;
  int cyc = 0, sav_cyc = 0, last_code = -1, last_eav = 0, run = 0;
  bit sav_ok = 1'b0, have_eav = 1'b0;
  logic [7:0] e_dout = 8'h00;
  logic [2:0] e_fvh = 3'b000;
  bit e_de = 1'b0, e_lock = 1'b0;
  int de_count = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_sync_decoder u_vid_sync_decoder (
    .clk(clk), .rst_n(rst_n), .sel_625(sel_625), .din(din),
    .dout(dout), .de(de), .h_flag(h_flag), .v_flag(v_flag),
    .f_flag(f_flag), .locked(locked)
  );

  function automatic int line_len(input bit s625);
    return s625 ? (4 + 280 + 4 + ACT) : (4 + 268 + 4 + ACT);
  endfunction

  function automatic logic [7:0] make_xy(input bit f, input bit v, input bit h);
    return {1'b1, f, v, h, 4'($urandom_range(15, 0))};
  endfunction

  function automatic logic [7:0] rand_data();
    return 8'($urandom_range(254, 1));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic observe();
    check(dout == e_dout, "R5 dout", int'(dout), int'(e_dout));
    check(de == e_de, "R6 de", int'(de), int'(e_de));
    check({f_flag, v_flag, h_flag} == e_fvh, "R3 flags",
          int'({f_flag, v_flag, h_flag}), int'(e_fvh));
    check(locked == e_lock, "R8 locked", int'(locked), int'(e_lock));
    if (de) de_count++;
  endtask

  task automatic send(input logic [7:0] b);
    int ln;
    bit code;
    @(negedge clk);
    observe();
    din = b;
    ln = line_len(sel_625);
    code = (m2 == 8'hFF) && (m1 == 8'h00) && (m0 == 8'h00) && b[7];
    e_dout = b;
    if (code) begin
      last_code = cyc;
      e_fvh = b[6:4];
      if (!b[4] && !b[5]) begin
        sav_ok = 1'b1;
        sav_cyc = cyc;
      end
    end
    e_de = !code && sav_ok && (last_code == sav_cyc) && ((cyc - sav_cyc) <= ACT);
    if (code && b[4]) begin
      if (have_eav && (cyc - last_eav) == ln) run = (run < 2) ? run + 1 : 2;
      else run = 0;
      have_eav = 1'b1;
      last_eav = cyc;
    end else if (have_eav && (cyc - last_eav) >= ln) begin
      run = 0;
      have_eav = 1'b0;
    end
    e_lock = (run == 2);
    m2 = m1; m1 = m0; m0 = b;
    cyc++;
  endtask

  // one line: end code, blanking, start code, active bytes
  task automatic send_line(input bit f, input bit v, input int blank, input bit inject);
    send(8'hFF);
    de_count = 0;
    send(8'h00); send(8'h00); send(make_xy(f, v, 1'b1));
    for (int i = 0; i < blank; i++) send(rand_data());
    send(8'hFF); send(8'h00); send(8'h00); send(make_xy(f, v, 1'b0));
    for (int i = 0; i < ACT; i++) begin
      if (inject && i == 100) send(8'hFF);
      else if (inject && i == 101) send(8'h00);
      else if (inject && i == 102) send(8'hFF);
      else if (inject && i == 103) send(8'h00);
      else if (inject && i == 104) send(8'h00);
      else if (inject && i == 105) send(8'h7F);
      else send(rand_data());
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd7177));
    repeat (3) @(posedge clk);
    // R1: outputs during reset
    check({dout, de, h_flag, v_flag, f_flag, locked} == '0, "R1 in reset",
          int'({dout, de, h_flag, v_flag, f_flag, locked}), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check({dout, de, h_flag, v_flag, f_flag, locked} == '0, "R1 after reset",
          int'({dout, de, h_flag, v_flag, f_flag, locked}), 0);

    // R8: acquire lock on 525-line spacing; R2 with F=1 and random low nibble
    for (int n = 0; n < 4; n++) send_line(1'b1, 1'b0, 268, 1'b0);
    check(locked == 1'b1, "R8 lock 525", int'(locked), 1);
    check(f_flag == 1'b1 && v_flag == 1'b0 && h_flag == 1'b0, "R2 sav flags",
          int'({f_flag, v_flag, h_flag}), 3'b100);

    // R7: vertical blank line keeps de low (count excludes the last byte's slot)
    send_line(1'b0, 1'b1, 268, 1'b0);
    check(de_count == 0, "R7 de in vblank", de_count, 0);
    check(v_flag == 1'b1, "R2 v flag", int'(v_flag), 1);

    // R4: partial preamble and bit7=0 status inside active data
    send_line(1'b0, 1'b0, 268, 1'b1);
    check(de_count == ACT - 1, "R4 de run", de_count, ACT - 1);
    check({f_flag, v_flag, h_flag} == 3'b000, "R4 flags kept",
          int'({f_flag, v_flag, h_flag}), 0);
    check(locked == 1'b1, "R4 lock kept", int'(locked), 1);

    // R9: short line breaks spacing
    send_line(1'b0, 1'b0, 267, 1'b0);
    send_line(1'b0, 1'b0, 268, 1'b0);
    check(locked == 1'b0, "R9 early code", int'(locked), 0);
    send_line(1'b0, 1'b0, 268, 1'b0);
    send_line(1'b0, 1'b0, 268, 1'b0);
    check(locked == 1'b1, "R9 relock", int'(locked), 1);

    // R10: codes stop
    for (int i = 0; i < line_len(1'b0) + 10; i++) send(rand_data());
    check(locked == 1'b0, "R10 no codes", int'(locked), 0);
    for (int n = 0; n < 3; n++) send_line(1'b1, 1'b0, 268, 1'b0);
    check(locked == 1'b1, "R10 relock", int'(locked), 1);

    // R10: code one clock late, timeout wins
    send_line(1'b1, 1'b0, 269, 1'b0);
    send_line(1'b1, 1'b0, 268, 1'b0);
    check(locked == 1'b0, "R10 late code", int'(locked), 0);

    // R8: 625-line spacing
    sel_625 = 1'b1;
    for (int n = 0; n < 4; n++) send_line(1'b0, 1'b0, 280, 1'b0);
    check(locked == 1'b1, "R8 lock 625", int'(locked), 1);
    send(8'hFF);
    finish_run();
  end

endmodule